// File: doc/BRIEF.md
# Binary64 Floating-Point Adder

This unit adds two IEEE 754 binary64 operands and returns the binary64 sum together with the invalid, inexact, overflow and underflow flags. The caller forms a subtraction by inverting the sign bit of the second operand before presenting it. The exponent and fraction widths are parameters. The defaults give binary64, and smaller settings give narrower formats that behave the same way.

Each operand is first classified as zero, normal, subnormal, infinity, quiet NaN or signalling NaN. Any pair that contains a NaN, an infinity or a zero is resolved by a fixed priority ladder. The other pairs take the arithmetic path:

- Subnormal operands are renormalised.
- The smaller operand is aligned with guard, round and sticky bits kept.
- The magnitudes are added or subtracted, and the result is normalised.
- The result is rounded under one of four modes and then packed.

A single output register holds the result. It is presented one cycle after the strobed operands.

Top module: `fpadd_dp`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge, and `sum` and the flags hold the result for those operands. When `in_valid` is low at an edge, `out_valid` is low after it and `sum` keeps its value. Synchronous reset clears `out_valid`, `sum` and all flags.
- R2: If x is a signalling NaN (exponent all ones, top fraction bit 0, fraction nonzero), the result is x with its top fraction bit set, and invalid is raised, whatever y is.
- R3: If y is a signalling NaN and x is not, the result is y with its top fraction bit set and invalid is raised. This holds even when x is a quiet NaN.
- R4: If neither operand is a signalling NaN and x is a quiet NaN (top fraction bit 1), the result is x bit for bit. Otherwise, a quiet NaN in y is returned bit for bit. No flag is raised.
- R5: The sum of two infinities of equal sign is x. Infinities of opposite sign raise invalid and give the default NaN: sign 0, exponent all ones, top fraction bit 1, and the other fraction bits 0.
- R6: An infinity added to any zero or finite value returns the infinity operand unchanged, with no flag.
- R7: Two zeros of equal sign return x. Two zeros of opposite sign return +0 in rounding modes 0 to 2 and -0 in mode 3.
- R8: A finite nonzero operand added to a zero of either sign is returned bit for bit, with no flag.
- R9: `rnd_mode` selects the rounding: 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. Every finite sum equals the exact sum rounded in the selected mode. An exact cancellation gives a zero signed as in R7.
- R10: Inexact is raised exactly when the rounded result differs from the exact sum.
- R11: When the rounded exponent reaches all ones, overflow and inexact are both raised. The result is infinity in mode 0, in mode 2 for a positive sum and in mode 3 for a negative sum. In every other case it is the largest finite value of the sum's sign.
- R12: A result below the normal range is encoded as a subnormal. Underflow is raised only when such a result is also inexact, so an exact subnormal sum raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_x | input | EXP_W+FRAC_W+1 | First addend |
| op_y | input | EXP_W+FRAC_W+1 | Second addend |
| rnd_mode | input | 2 | Rounding mode: 0 nearest even, 1 toward zero, 2 up, 3 down |
| out_valid | output | 1 | `sum` and the flags hold a new result |
| sum | output | EXP_W+FRAC_W+1 | Rounded sum |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Rounded result differs from the exact sum |
| flag_overflow | output | 1 | Result exceeded the finite range |
| flag_underflow | output | 1 | Result is subnormal and inexact |

## Verification
The assertions assume that `in_valid` and the operand and mode inputs are never X at a sampled edge. They also assume that the magnitude ordering feeding the arithmetic path only ever sees finite nonzero operands.

The bench drives the inputs at every falling edge from the first clock onward. It never leaves them undefined, and it only presents legal two-bit mode values.

The bench is built for a one-byte format: 4 exponent bits and 3 fraction bits. Every operand pair is swept under nearest-even rounding. A strided subset of pairs is swept under each of the other modes. Each finite sum is compared with an exact integer sum that the bench rounds arithmetically.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        CL_ZERO  = 3'd0,
        CL_NORM  = 3'd1,
        CL_SUB   = 3'd2,
        CL_INF   = 3'd3,
        CL_QNAN  = 3'd4,
        CL_SNAN  = 3'd5
    } fp_class_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
        logic overflow;
        logic underflow;
    } fp_flags_t;

    // Sign of a zero produced by cancelling operands of opposite sign.
    function automatic logic cancel_sign(input rmode_e rm);
        return rm == RM_DOWN;
    endfunction

endpackage

// File: rtl/fpadd_sticky_shr.sv
module fpadd_sticky_shr #(
    parameter int WIDTH = 56,
    parameter int SHW   = 6
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amount,
    output logic [WIDTH-1:0] dout
);
    // Right shift; every bit pushed off the low end is folded into bit 0.
    always_comb begin
        logic [WIDTH-1:0] r;
        logic lost;
        r    = din;
        lost = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (i < int'(amount)) begin
                lost = lost | r[0];
                r    = r >> 1;
            end
        end
        dout = {r[WIDTH-1:1], r[0] | lost};
    end
endmodule

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]  op,
    output logic                   sign,
    output fp_class_e              cls,
    output logic signed [EXP_W+1:0] exp_n,
    output logic [FRAC_W:0]        mant_n
);
    localparam int XW  = EXP_W + 2;
    localparam int LZW = $clog2(FRAC_W + 1) + 1;

    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;
    logic [LZW-1:0]    lz;

    assign sign = op[EXP_W+FRAC_W];
    assign ef   = op[EXP_W+FRAC_W-1:FRAC_W];
    assign ff   = op[FRAC_W-1:0];

    always_comb begin
        if (&ef)
            cls = (ff == '0) ? CL_INF : (ff[FRAC_W-1] ? CL_QNAN : CL_SNAN);
        else if (ef == '0)
            cls = (ff == '0) ? CL_ZERO : CL_SUB;
        else
            cls = CL_NORM;
    end

    // Leading zeros of the fraction, used to renormalise subnormals.
    always_comb begin
        logic found;
        lz    = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (ff[i]) found = 1'b1;
                else       lz = lz + 1'b1;
            end
        end
    end

    always_comb begin
        if (ef == '0) begin
            mant_n = {1'b0, ff} << (lz + 1'b1);
            exp_n  = -$signed({{(XW-LZW){1'b0}}, lz});
        end else begin
            mant_n = {1'b1, ff};
            exp_n  = $signed({{(XW-EXP_W){1'b0}}, ef});
        end
    end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] x,
    input  logic [EXP_W+FRAC_W:0] y,
    input  fp_class_e             cls_x,
    input  fp_class_e             cls_y,
    input  rmode_e                rm,
    output logic                  hit,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  invalid
);
    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic sx, sy;
    assign sx = x[W-1];
    assign sy = y[W-1];

    // Fixed priority ladder over the operand classes.
    always_comb begin
        hit     = 1'b1;
        invalid = 1'b0;
        res     = x;
        if (cls_x == CL_SNAN) begin
            res = x | QUIET_BIT;  invalid = 1'b1;
        end else if (cls_y == CL_SNAN) begin
            res = y | QUIET_BIT;  invalid = 1'b1;
        end else if (cls_x == CL_QNAN) begin
            res = x;
        end else if (cls_y == CL_QNAN) begin
            res = y;
        end else if (cls_x == CL_INF && cls_y == CL_INF) begin
            if (sx == sy) res = x;
            else begin
                res = DFLT_NAN;  invalid = 1'b1;
            end
        end else if (cls_x == CL_INF) begin
            res = x;
        end else if (cls_y == CL_INF) begin
            res = y;
        end else if (cls_x == CL_ZERO && cls_y == CL_ZERO) begin
            res = (sx == sy) ? x : {cancel_sign(rm), {(W-1){1'b0}}};
        end else if (cls_y == CL_ZERO) begin
            res = x;
        end else if (cls_x == CL_ZERO) begin
            res = y;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fpadd_addnorm.sv
module fpadd_addnorm #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                    sx,
    input  logic signed [EXP_W+1:0] ex,
    input  logic [FRAC_W:0]         mx,
    input  logic                    sy,
    input  logic signed [EXP_W+1:0] ey,
    input  logic [FRAC_W:0]         my,
    output logic                    rs,
    output logic signed [EXP_W+1:0] re,
    output logic [FRAC_W+3:0]       rmant,
    output logic                    rzero
);
    localparam int XW  = EXP_W + 2;
    localparam int MW  = FRAC_W + 1;
    localparam int GW  = MW + 3;
    localparam int SHW = $clog2(GW + 1);

    logic                 x_big;
    logic                 sb;
    logic signed [XW-1:0] eb, es;
    logic [MW-1:0]        mb, ms;
    logic [SHW-1:0]       sh;
    logic [GW-1:0]        al;
    logic [GW:0]          wide_sum;
    logic [GW-1:0]        carry_sh;
    logic [GW-1:0]        diff;

    assign x_big = (ex > ey) || (ex == ey && mx >= my);
    assign sb = x_big ? sx : sy;
    assign eb = x_big ? ex : ey;
    assign es = x_big ? ey : ex;
    assign mb = x_big ? mx : my;
    assign ms = x_big ? my : mx;

    always_comb begin
        int d;
        d  = int'(eb) - int'(es);
        sh = (d > GW) ? SHW'(GW) : SHW'(d);
    end

    fpadd_sticky_shr #(.WIDTH(GW), .SHW(SHW)) u_align (
        .din({ms, 3'b000}), .amount(sh), .dout(al)
    );

    assign wide_sum = {1'b0, mb, 3'b000} + {1'b0, al};
    assign diff     = {mb, 3'b000} - al;

    fpadd_sticky_shr #(.WIDTH(GW), .SHW(SHW)) u_carry (
        .din(wide_sum[GW:1]), .amount(SHW'(0)), .dout(carry_sh)
    );

    always_comb begin
        logic [SHW-1:0] lz;
        logic found;
        lz    = '0;
        found = 1'b0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (!found) begin
                if (diff[i]) found = 1'b1;
                else         lz = lz + 1'b1;
            end
        end
        rs    = sb;
        rzero = 1'b0;
        if (sx == sy) begin
            if (wide_sum[GW]) begin
                rmant = {carry_sh[GW-1:1], carry_sh[0] | wide_sum[0]};
                re    = XW'(int'(eb) + 1);
            end else begin
                rmant = wide_sum[GW-1:0];
                re    = eb;
            end
        end else begin
            rzero = (diff == '0);
            rmant = diff << lz;
            re    = XW'(int'(eb) - int'(lz));
        end
    end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                    sgn,
    input  logic signed [EXP_W+1:0] e,
    input  logic [FRAC_W+3:0]       m,
    input  rmode_e                  rm,
    output logic [EXP_W+FRAC_W:0]   res,
    output logic                    inexact,
    output logic                    overflow,
    output logic                    underflow
);
    localparam int MW   = FRAC_W + 1;
    localparam int GW   = MW + 3;
    localparam int SHW  = $clog2(GW + 1);
    localparam int EMAX = (1 << EXP_W) - 1;

    logic           tiny;
    logic [SHW-1:0] dn_sh;
    logic [GW-1:0]  md;
    logic [MW-1:0]  t;
    logic           g, rst_bits, up, exact;
    logic [MW:0]    tr;

    assign tiny = int'(e) < 1;

    always_comb begin
        int d;
        d     = 1 - int'(e);
        dn_sh = !tiny ? '0 : ((d > GW) ? SHW'(GW) : SHW'(d));
    end

    fpadd_sticky_shr #(.WIDTH(GW), .SHW(SHW)) u_denorm (
        .din(m), .amount(dn_sh), .dout(md)
    );

    assign t        = md[GW-1:3];
    assign g        = md[2];
    assign rst_bits = md[1] | md[0];
    assign exact    = !(g | rst_bits);

    always_comb begin
        unique case (rm)
            RM_NEAR: up = g & (rst_bits | t[0]);
            RM_ZERO: up = 1'b0;
            RM_UP:   up = !exact & !sgn;
            RM_DOWN: up = !exact & sgn;
            default: up = 1'b0;
        endcase
    end

    assign tr = {1'b0, t} + {{MW{1'b0}}, up};

    always_comb begin
        int ef;
        logic [FRAC_W-1:0] frac;
        logic to_inf;
        if (tiny) begin
            ef   = tr[FRAC_W] ? 1 : 0;
            frac = tr[FRAC_W-1:0];
        end else if (tr[MW]) begin
            ef   = int'(e) + 1;
            frac = '0;
        end else begin
            ef   = int'(e);
            frac = tr[FRAC_W-1:0];
        end
        overflow  = !tiny && ef >= EMAX;
        to_inf    = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);
        inexact   = !exact || overflow;
        underflow = tiny && !exact;
        if (overflow)
            res = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        else
            res = {sgn, EXP_W'(ef), frac};
    end
endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  op_x,
    input  logic [EXP_W+FRAC_W:0]  op_y,
    input  logic [1:0]             rnd_mode,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  sum,
    output logic                   flag_invalid,
    output logic                   flag_inexact,
    output logic                   flag_overflow,
    output logic                   flag_underflow
);
    localparam int W  = EXP_W + FRAC_W + 1;
    localparam int XW = EXP_W + 2;
    localparam int GW = FRAC_W + 4;

    rmode_e rm;
    assign rm = rmode_e'(rnd_mode);

    logic sx, sy;
    fp_class_e cx, cy;
    logic signed [XW-1:0] ex, ey;
    logic [FRAC_W:0] mx, my;

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unx (
        .op(op_x), .sign(sx), .cls(cx), .exp_n(ex), .mant_n(mx));
    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_uny (
        .op(op_y), .sign(sy), .cls(cy), .exp_n(ey), .mant_n(my));

    logic sp_hit, sp_inv;
    logic [W-1:0] sp_res;
    fpadd_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
        .x(op_x), .y(op_y), .cls_x(cx), .cls_y(cy), .rm(rm),
        .hit(sp_hit), .res(sp_res), .invalid(sp_inv));

    logic an_s, an_zero;
    logic signed [XW-1:0] an_e;
    logic [GW-1:0] an_m;
    fpadd_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_arith (
        .sx(sx), .ex(ex), .mx(mx), .sy(sy), .ey(ey), .my(my),
        .rs(an_s), .re(an_e), .rmant(an_m), .rzero(an_zero));

    logic [W-1:0] rd_res;
    logic rd_inx, rd_ovf, rd_unf;
    fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sgn(an_s), .e(an_e), .m(an_m), .rm(rm),
        .res(rd_res), .inexact(rd_inx), .overflow(rd_ovf), .underflow(rd_unf));

    logic [W-1:0] nxt_res;
    fp_flags_t    nxt_fl;

    always_comb begin
        if (sp_hit) begin
            nxt_res = sp_res;
            nxt_fl  = '{invalid: sp_inv, inexact: 1'b0, overflow: 1'b0, underflow: 1'b0};
        end else if (an_zero) begin
            nxt_res = {cancel_sign(rm), {(W-1){1'b0}}};
            nxt_fl  = '0;
        end else begin
            nxt_res = rd_res;
            nxt_fl  = '{invalid: 1'b0, inexact: rd_inx, overflow: rd_ovf, underflow: rd_unf};
        end
    end

    fp_flags_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum       <= '0;
            fl_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum  <= nxt_res;
                fl_q <= nxt_fl;
            end
        end
    end

    assign flag_invalid   = fl_q.invalid;
    assign flag_inexact   = fl_q.inexact;
    assign flag_overflow  = fl_q.overflow;
    assign flag_underflow = fl_q.underflow;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(sum)));
    // R5
    invalid_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> ((&sum[W-2:FRAC_W]) && sum[FRAC_W-1]));
    // R9
    norm_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sp_hit && !an_zero) |-> an_m[GW-1]);
    // R11
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        flag_overflow |-> flag_inexact);
    // R12
    unf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        flag_underflow |-> (flag_inexact && sum[W-2:FRAC_W] == '0));
endmodule

// File: tb/fpadd_dp_test.sv
`timescale 1ns/1ps
module fpadd_dp_test;
    localparam int EW = 4;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] op_x = '0, op_y = '0;
    logic [1:0] rnd_mode = '0;
    logic out_valid;
    logic [7:0] sum;
    logic f_inv, f_inx, f_ovf, f_unf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpadd_dp #(.EXP_W(EW), .FRAC_W(FW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .sum(sum),
        .flag_invalid(f_inv), .flag_inexact(f_inx),
        .flag_overflow(f_ovf), .flag_underflow(f_unf));

    // Flags packed as {invalid, inexact, overflow, underflow}.
    task automatic ref_add(input logic [7:0] x, input logic [7:0] y, input logic [1:0] rm,
                           output logic [7:0] r, output logic [3:0] fl, output string tag);
        int ex, ey, fx, fy, vx, vy, s, mag, k, t, rem, q, e;
        logic sx, sy, neg, up;
        sx = x[7]; sy = y[7];
        ex = int'(x[6:3]); ey = int'(y[6:3]);
        fx = int'(x[2:0]); fy = int'(y[2:0]);
        fl = 4'b0000; r = 8'h00; tag = "R9";
        if (ex == 15 && fx != 0 && !x[2]) begin
            r = x | 8'h04; fl = 4'b1000; tag = "R2";
        end else if (ey == 15 && fy != 0 && !y[2]) begin
            r = y | 8'h04; fl = 4'b1000; tag = "R3";
        end else if (ex == 15 && x[2]) begin
            r = x; tag = "R4";
        end else if (ey == 15 && y[2]) begin
            r = y; tag = "R4";
        end else if (ex == 15 && ey == 15) begin
            tag = "R5";
            if (sx == sy) r = x;
            else begin r = 8'h7C; fl = 4'b1000; end
        end else if (ex == 15) begin
            r = x; tag = "R6";
        end else if (ey == 15) begin
            r = y; tag = "R6";
        end else if (x[6:0] == 0 && y[6:0] == 0) begin
            tag = "R7";
            r = (sx == sy) ? x : {rm == 2'd3, 7'b0};
        end else if (y[6:0] == 0) begin
            r = x; tag = "R8";
        end else if (x[6:0] == 0) begin
            r = y; tag = "R8";
        end else begin
            vx = (ex == 0) ? fx : (8 + fx) << (ex - 1);
            vy = (ey == 0) ? fy : (8 + fy) << (ey - 1);
            s = (sx ? -vx : vx) + (sy ? -vy : vy);
            if (s == 0) begin
                r = {rm == 2'd3, 7'b0}; tag = "R9";
            end else begin
                neg = s < 0;
                mag = neg ? -s : s;
                if (mag < 8) begin
                    r = {neg, 4'b0000, 3'(mag)}; tag = "R12";
                end else begin
                    k = 3;
                    while ((mag >> (k + 1)) != 0) k++;
                    t = mag >> (k - 3);
                    rem = mag - (t << (k - 3));
                    q = 1 << (k - 3);
                    e = k - 2;
                    case (rm)
                        2'd0: up = (2 * rem > q) || (2 * rem == q && (t % 2) == 1);
                        2'd1: up = 1'b0;
                        2'd2: up = (rem != 0) && !neg;
                        default: up = (rem != 0) && neg;
                    endcase
                    if (up) t++;
                    if (t == 16) begin t = 8; e++; end
                    if (e >= 15) begin
                        fl = 4'b0110; tag = "R11";
                        if (rm == 2'd0 || (rm == 2'd2 && !neg) || (rm == 2'd3 && neg))
                            r = {neg, 7'h78};
                        else
                            r = {neg, 7'h77};
                    end else begin
                        r = {neg, 4'(e), 3'(t)};
                        if (rem != 0) begin fl = 4'b0100; tag = "R10"; end
                        else tag = "R9";
                    end
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp,
                         input logic [7:0] x, input logic [7:0] y, input logic [1:0] rm);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: x=%h y=%h mode=%0d actual=%h expected=%h", tag, x, y, rm, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] px, py, pr;
        logic [3:0] pf;
        logic [1:0] pm;
        string ptag;
        bit have_prev;
        have_prev = 1'b0;
        px = '0; py = '0; pr = '0; pf = '0; pm = '0; ptag = "";
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, sum, f_inv, f_inx, f_ovf, f_unf}, 13'h0, 8'h0, 8'h0, 2'd0);
        rst = 1'b0;
        for (int m = 0; m < 4; m++) begin
            for (int xi = 0; xi < 256; xi++) begin
                for (int yi = 0; yi < 256; yi += ((m == 0) ? 1 : 8)) begin
                    @(negedge clk);
                    if (have_prev)
                        check(ptag, {out_valid, sum, f_inv, f_inx, f_ovf, f_unf},
                              {1'b1, pr, pf}, px, py, pm);
                    op_x = 8'(xi); op_y = 8'(yi + m); rnd_mode = 2'(m); in_valid = 1'b1;
                    px = op_x; py = op_y; pm = rnd_mode;
                    ref_add(px, py, pm, pr, pf, ptag);
                    have_prev = 1'b1;
                end
            end
        end
        @(negedge clk);
        check(ptag, {out_valid, sum, f_inv, f_inx, f_ovf, f_unf}, {1'b1, pr, pf}, px, py, pm);
        in_valid = 1'b0;
        op_x = 8'h38; op_y = 8'h38;
        @(negedge clk);
        // R1: idle cycle drops out_valid and keeps the last result
        check("R1", {out_valid, sum, f_inv, f_inx, f_ovf, f_unf}, {1'b0, pr, pf}, px, py, pm);
        @(negedge clk);
        check("R1", {out_valid, sum, f_inv, f_inx, f_ovf, f_unf}, {1'b0, pr, pf}, px, py, pm);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule